// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the command pins of a two-bank synchronous DRAM and judges every command against the device state it arrives in. On each rising clock edge it samples the clock-enable, the chip select, the three command strobes, the bank-select address bit and the auto-precharge address bit. It then decodes the command and decides whether that command is allowed. It tracks which banks hold an open row. It also tracks the timed transient states: write recovery after a write with auto-precharge, refresh, mode-register load, and the clock-suspended sleep mode. Each transient state ends by itself after its own programmable cycle count.

The first illegal command raises a sticky error flag and records the command and the state it met. The tracked bank and device state are left untouched by the illegal command, so monitoring goes on in a meaningful way after an error. All recovery times are parameters counted in clock cycles, and each must be at least 1. A parameter T means that a command sampled exactly T edges after the starting command is judged as if the interval has elapsed.

Top module: `sdcmd_guard`

## Requirements
- R1: `cmd_o` decodes the sampled pins combinationally. CKE low gives 9 (sleep request). Otherwise chip select high gives 0 (deselect). With chip select low, {RAS,CAS,WE} = HHH gives 1 (no-op), HHL gives 2 (burst stop), HLH gives 3 (read), HLL gives 4 (write), LHH gives 5 (activate), LHL gives 6 (precharge), LLH gives 7 (refresh) and LLL gives 8 (mode load).
- R2: `state_o` reports the state in which the current pins will be judged. The codes are 0 idle (no bank open), 1 active (at least one bank open), 2 write recovery, 3 refresh, 4 mode load and 5 sleep.
- R3: Deselect, no-op and burst stop are legal in every state and change no bank.
- R4: Refresh and mode load are legal only in idle. They enter state 3 or 4, which lasts T_RP or T_MCD cycles. A command sampled that many edges later is judged in idle.
- R5: In refresh and mode load, every command other than deselect, no-op and burst stop is illegal.
- R6: A write with the auto-precharge bit set to an open bank enters write recovery for T_DAL cycles. At the end of that interval the written bank closes and the state becomes active or idle.
- R7: In write recovery, refresh, mode load, sleep requests, a precharge of all banks, any command to the recovering bank, and a second write with auto-precharge are illegal. Commands to the other bank follow the normal rules.
- R8: Activate is legal only to a closed bank, and only T_RRD or more edges after the previous activate.
- R9: Precharge with the auto-precharge bit clear closes the selected bank. It is illegal if that bank opened fewer than T_RAS edges earlier. Closing a closed bank is legal. With the bit set, all banks close, and every open bank must meet T_RAS.
- R10: Read and write need the selected bank open. A read with the auto-precharge bit set closes that bank.
- R11: CKE low is legal in idle and enters sleep (state 5). During sleep every pin other than CKE is ignored. CKE low in any other state is illegal. The first edge with CKE high is judged in idle.
- R12: After an illegal command, `err_flag` is set from the next cycle until reset. `err_code` holds {command[3:0], state[2:0]} of the first illegal command. The illegal command changes no bank or state, while the interval counters keep running.
- R13: Reset gives state idle, no bank open, `err_flag` 0 and `err_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Bank-select address bit |
| ap_bit | input | 1 | Auto-precharge / all-banks address bit |
| cmd_o | output | 4 | Decoded command code (R1) |
| state_o | output | 3 | Judging state code (R2) |
| err_flag | output | 1 | Sticky illegal-command flag |
| err_code | output | 7 | {command, state} of the first illegal command |

## Verification
The assertions assume that the pins are stable around the rising edge and that reset is applied before the first command. They also assume that a sleep request is judged with CKE alone, so a check on a sleep cycle never looks at the strobes. The stimulus changes pins just after each rising edge and holds them for exactly one sample. It releases reset only on a clock boundary, and it fills sleep cycles with random strobe values so that the ignored pins are really varied.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [3:0] {
      CMD_DESL  = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_BST   = 4'd2,
      CMD_READ  = 4'd3,
      CMD_WRITE = 4'd4,
      CMD_ACT   = 4'd5,
      CMD_PRE   = 4'd6,
      CMD_REF   = 4'd7,
      CMD_MRS   = 4'd8,
      CMD_PDN   = 4'd9
   } cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ACTIVE = 3'd1,
      ST_WREC   = 3'd2,
      ST_REFR   = 3'd3,
      ST_MODE   = 3'd4,
      ST_SLEEP  = 3'd5
   } st_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (!cke)
         cmd = CMD_PDN;
      else if (cs_n)
         cmd = CMD_DESL;
      else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b110:  cmd = CMD_BST;
            3'b101:  cmd = CMD_READ;
            3'b100:  cmd = CMD_WRITE;
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_MRS;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_countdown.sv
module sdcmd_countdown #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdcmd_guard.sv
module sdcmd_guard
   import sdcmd_pkg::*;
#(
   parameter int T_DAL = 4,
   parameter int T_RP  = 3,
   parameter int T_MCD = 2,
   parameter int T_RRD = 2,
   parameter int T_RAS = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       bank_sel,
   input  logic       ap_bit,
   output logic [3:0] cmd_o,
   output logic [2:0] state_o,
   output logic       err_flag,
   output logic [6:0] err_code
);
   localparam int NB    = 2;
   localparam int T_MAX = imax(imax(imax(T_DAL, T_RP), imax(T_MCD, T_RRD)), T_RAS);
   localparam int CW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

   localparam logic [CW-1:0] LD_DAL = CW'(T_DAL - 1);
   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] LD_MCD = CW'(T_MCD - 1);
   localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
   localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);

   generate
      if (T_DAL < 1 || T_RP < 1 || T_MCD < 1 || T_RRD < 1 || T_RAS < 1) begin : g_bad_timing
         $error("sdcmd_guard: every interval parameter must be at least one cycle");
      end
   endgenerate

   cmd_e              cmd;
   st_e               st_q, st_eff, nxt_st;
   logic [NB-1:0]     open_q, open_eff, nxt_open;
   logic              rb_q, nxt_rb;
   logic [NB-1:0]     ras_zero, ld_ras;
   logic              rrd_zero, ld_rrd;
   logic              tr_zero, ld_tr;
   logic [CW-1:0]     tr_val;
   logic              legal, normal, in_wrec, hit_rb;

   sdcmd_decode i_dec (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   // per-bank row-active interval
   generate
      for (genvar gb = 0; gb < NB; gb++) begin : g_ras
         sdcmd_countdown #(.W(CW)) i_ras (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld_ras[gb] & legal),
            .load_val (LD_RAS),
            .zero     (ras_zero[gb])
         );
      end
   endgenerate

   // activate-to-activate spacing; a one-cycle spacing needs no counter
   generate
      if (T_RRD > 1) begin : g_rrd_cnt
         sdcmd_countdown #(.W(CW)) i_rrd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld_rrd & legal),
            .load_val (LD_RRD),
            .zero     (rrd_zero)
         );
      end else begin : g_rrd_none
         assign rrd_zero = 1'b1;
      end
   endgenerate

   // shared interval for write recovery, refresh and mode load
   sdcmd_countdown #(.W(CW)) i_trans (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_tr & legal),
      .load_val (tr_val),
      .zero     (tr_zero)
   );

   // resolve expired intervals into the state the pins are judged in
   always_comb begin
      st_eff   = st_q;
      open_eff = open_q;
      unique case (st_q)
         ST_WREC: if (tr_zero) begin
            open_eff[rb_q] = 1'b0;
            st_eff = (|open_eff) ? ST_ACTIVE : ST_IDLE;
         end
         ST_REFR, ST_MODE: if (tr_zero) st_eff = ST_IDLE;
         ST_SLEEP:         if (cke)     st_eff = ST_IDLE;
         default: ;
      endcase
   end

   assign normal  = (st_eff == ST_IDLE) || (st_eff == ST_ACTIVE) || (st_eff == ST_WREC);
   assign in_wrec = (st_eff == ST_WREC);
   assign hit_rb  = in_wrec && (bank_sel == rb_q);

   always_comb begin
      legal    = 1'b0;
      nxt_st   = st_eff;
      nxt_open = open_eff;
      nxt_rb   = rb_q;
      ld_ras   = '0;
      ld_rrd   = 1'b0;
      ld_tr    = 1'b0;
      tr_val   = LD_DAL;
      unique case (cmd)
         CMD_DESL, CMD_NOP, CMD_BST: legal = 1'b1;
         CMD_PDN: begin
            legal  = (st_eff == ST_IDLE) || (st_eff == ST_SLEEP);
            nxt_st = ST_SLEEP;
         end
         CMD_REF: begin
            legal  = (st_eff == ST_IDLE);
            nxt_st = ST_REFR;
            ld_tr  = 1'b1;
            tr_val = LD_RP;
         end
         CMD_MRS: begin
            legal  = (st_eff == ST_IDLE);
            nxt_st = ST_MODE;
            ld_tr  = 1'b1;
            tr_val = LD_MCD;
         end
         CMD_ACT: begin
            legal              = normal && !open_eff[bank_sel] && rrd_zero;
            nxt_open[bank_sel] = 1'b1;
            ld_ras[bank_sel]   = 1'b1;
            ld_rrd             = 1'b1;
         end
         CMD_READ: begin
            legal = normal && open_eff[bank_sel] && !hit_rb;
            if (ap_bit) nxt_open[bank_sel] = 1'b0;
         end
         CMD_WRITE: begin
            legal = normal && open_eff[bank_sel] && !hit_rb && !(in_wrec && ap_bit);
            if (ap_bit) begin
               nxt_st = ST_WREC;
               nxt_rb = bank_sel;
               ld_tr  = 1'b1;
               tr_val = LD_DAL;
            end
         end
         CMD_PRE: begin
            if (ap_bit) begin
               legal    = normal && !in_wrec && &(~open_eff | ras_zero);
               nxt_open = '0;
            end else begin
               legal = normal && !hit_rb && (!open_eff[bank_sel] || ras_zero[bank_sel]);
               nxt_open[bank_sel] = 1'b0;
            end
         end
         default: legal = 1'b0;
      endcase
      if (nxt_st == ST_IDLE || nxt_st == ST_ACTIVE)
         nxt_st = (|nxt_open) ? ST_ACTIVE : ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         open_q   <= '0;
         rb_q     <= 1'b0;
         err_flag <= 1'b0;
         err_code <= '0;
      end else begin
         if (legal) begin
            st_q   <= nxt_st;
            open_q <= nxt_open;
            rb_q   <= nxt_rb;
         end else begin
            st_q   <= st_eff;
            open_q <= open_eff;
         end
         if (!legal && !err_flag) begin
            err_flag <= 1'b1;
            err_code <= {cmd, st_eff};
         end
      end
   end

   assign cmd_o   = cmd;
   assign state_o = st_eff;
endmodule

// File: rtl/sdcmd_guard_chk.sv
module sdcmd_guard_chk
   import sdcmd_pkg::*;
#(
   parameter int T_RP = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic [3:0] cmd_o,
   input logic [2:0] state_o,
   input logic       err_flag,
   input logic [6:0] err_code,
   input logic [1:0] open_q
);
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R12
   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> $stable(err_code)); // R12
   AST_QUIET_CMD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_flag && (cmd_o == CMD_DESL || cmd_o == CMD_NOP || cmd_o == CMD_BST)) |=> !err_flag); // R3
   AST_REFRESH_BUSY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_flag && state_o == ST_REFR && cmd_o == CMD_MRS) |=> (err_flag && err_code == {CMD_MRS, ST_REFR})); // R5
   AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_ACTIVE && cmd_o == CMD_REF) |=> err_flag); // R4
   AST_SLEEP_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_ACTIVE && cmd_o == CMD_PDN) |=> err_flag); // R11
   AST_SLEEP_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_SLEEP) |-> !cke); // R11
   AST_ACTIVE_HAS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_ACTIVE) |-> (open_q != 2'b00)); // R2

   generate
      if (T_RP > 1) begin : g_ref_entry
         AST_REF_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
            (!err_flag && state_o == ST_IDLE && cmd_o == CMD_REF) |=> (state_o == ST_REFR)); // R4
      end
   endgenerate
endmodule

bind sdcmd_guard sdcmd_guard_chk #(.T_RP(T_RP)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cke      (cke),
   .cmd_o    (cmd_o),
   .state_o  (state_o),
   .err_flag (err_flag),
   .err_code (err_code),
   .open_q   (open_q)
);

// File: tb/test_sdcmd_guard.sv
module test_sdcmd_guard;
   localparam int T_DAL = 4;
   localparam int T_RP  = 3;
   localparam int T_MCD = 2;
   localparam int T_RRD = 2;
   localparam int T_RAS = 5;

   localparam int C_DESL = 0, C_NOP = 1, C_BST = 2, C_READ = 3, C_WRITE = 4;
   localparam int C_ACT = 5, C_PRE = 6, C_REF = 7, C_MRS = 8, C_PDN = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic bank_sel = 1'b0, ap_bit = 1'b0;
   logic [3:0] cmd_o;
   logic [2:0] state_o;
   logic       err_flag;
   logic [6:0] err_code;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R13";

   // behavioural reference state
   int   m_state = 0;
   bit   m_open[2] = '{0, 0};
   int   m_ras[2] = '{0, 0};
   int   m_rrd = 0;
   int   m_t = 0;
   int   m_rb = 0;
   bit   m_flag = 0;
   int   m_code = 0;

   always #4 clk = ~clk;

   sdcmd_guard #(.T_DAL(T_DAL), .T_RP(T_RP), .T_MCD(T_MCD), .T_RRD(T_RRD), .T_RAS(T_RAS))
   i_sdcmd_guard (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .bank_sel(bank_sel), .ap_bit(ap_bit), .cmd_o(cmd_o), .state_o(state_o),
      .err_flag(err_flag), .err_code(err_code)
   );

   function automatic int pin_cmd();
      if (!cke) return C_PDN;
      if (cs_n) return C_DESL;
      case ({ras_n, cas_n, we_n})
         3'b111: return C_NOP;
         3'b110: return C_BST;
         3'b101: return C_READ;
         3'b100: return C_WRITE;
         3'b011: return C_ACT;
         3'b010: return C_PRE;
         3'b001: return C_REF;
         default: return C_MRS;
      endcase
   endfunction

   function automatic int judged_state();
      int s = m_state;
      if (s == 2 && m_t == 0) begin
         bit other = m_open[1 - m_rb];
         s = other ? 1 : 0;
      end
      if ((s == 3 || s == 4) && m_t == 0) s = 0;
      if (s == 5 && cke) s = 0;
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_open = '{0, 0}; m_ras = '{0, 0};
         m_rrd = 0; m_t = 0; m_rb = 0; m_flag = 0; m_code = 0;
      end else begin
         int  s, c, b, ns, nrb;
         bit  ok, a, in_n, wr, hit;
         bit  o[2], no[2];
         bit  ld_ras[2];
         bit  ld_rrd, ld_t;
         int  tv;
         s = judged_state();
         o = m_open;
         if (m_state == 2 && m_t == 0) o[m_rb] = 0;
         c = pin_cmd();
         b = int'(bank_sel);
         a = ap_bit;
         in_n = (s <= 2);
         wr = (s == 2);
         hit = wr && (b == m_rb);
         no = o; ns = s; nrb = m_rb; ok = 0;
         ld_ras = '{0, 0}; ld_rrd = 0; ld_t = 0; tv = 0;
         case (c)
            C_DESL, C_NOP, C_BST: ok = 1;
            C_PDN: begin ok = (s == 0 || s == 5); ns = 5; end
            C_REF: begin ok = (s == 0); ns = 3; ld_t = 1; tv = T_RP - 1; end
            C_MRS: begin ok = (s == 0); ns = 4; ld_t = 1; tv = T_MCD - 1; end
            C_ACT: begin
               ok = in_n && !o[b] && m_rrd == 0;
               no[b] = 1; ld_ras[b] = 1; ld_rrd = 1;
            end
            C_READ: begin
               ok = in_n && o[b] && !hit;
               if (a) no[b] = 0;
            end
            C_WRITE: begin
               ok = in_n && o[b] && !hit && !(wr && a);
               if (a) begin ns = 2; nrb = b; ld_t = 1; tv = T_DAL - 1; end
            end
            default: begin
               if (a) begin
                  ok = in_n && !wr && (!o[0] || m_ras[0] == 0) && (!o[1] || m_ras[1] == 0);
                  no = '{0, 0};
               end else begin
                  ok = in_n && !hit && (!o[b] || m_ras[b] == 0);
                  no[b] = 0;
               end
            end
         endcase
         if (ns == 0 || ns == 1) ns = (no[0] || no[1]) ? 1 : 0;
         for (int i = 0; i < 2; i++) if (m_ras[i] > 0) m_ras[i]--;
         if (m_rrd > 0) m_rrd--;
         if (m_t > 0) m_t--;
         if (ok) begin
            for (int i = 0; i < 2; i++) if (ld_ras[i]) m_ras[i] = T_RAS - 1;
            if (ld_rrd) m_rrd = T_RRD - 1;
            if (ld_t) m_t = tv;
            m_state = ns; m_open = no; m_rb = nrb;
         end else begin
            m_state = s; m_open = o;
            if (!m_flag) m_code = c * 8 + s;
            m_flag = 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int'(cmd_o) == pin_cmd(), tag, "cmd_o", int'(cmd_o), pin_cmd());
         check(int'(state_o) == judged_state(), tag, "state_o", int'(state_o), judged_state());
         check(err_flag == m_flag, tag, "err_flag", int'(err_flag), int'(m_flag));
         check(int'(err_code) == m_code, tag, "err_code", int'(err_code), m_code);
      end
   end

   task automatic drive(input int c, input bit b, input bit a);
      @(posedge clk);
      #1;
      bank_sel = b;
      ap_bit = a;
      cke = 1'b1;
      cs_n = 1'b0;
      case (c)
         C_DESL:  begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'($urandom_range(0, 7)); end
         C_NOP:   {ras_n, cas_n, we_n} = 3'b111;
         C_BST:   {ras_n, cas_n, we_n} = 3'b110;
         C_READ:  {ras_n, cas_n, we_n} = 3'b101;
         C_WRITE: {ras_n, cas_n, we_n} = 3'b100;
         C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
         C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
         C_REF:   {ras_n, cas_n, we_n} = 3'b001;
         C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
         default: begin
            cke = 1'b0;
            cs_n = 1'($urandom_range(0, 1));
            {ras_n, cas_n, we_n} = 3'($urandom_range(0, 7));
            bank_sel = 1'($urandom_range(0, 1));
            ap_bit = 1'($urandom_range(0, 1));
         end
      endcase
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) drive(C_NOP, 1'b0, 1'b0);
   endtask

   // hold a no-op over the edge that samples the previous command, then look
   task automatic settle(input bit eflag, input int est, input int ecode, input string req);
      drive(C_NOP, 1'b0, 1'b0);
      @(negedge clk);
      check(err_flag == eflag, req, "settled err_flag", int'(err_flag), int'(eflag));
      if (est >= 0) check(int'(state_o) == est, req, "settled state_o", int'(state_o), est);
      if (ecode >= 0) check(int'(err_code) == ecode, req, "settled err_code", int'(err_code), ecode);
   endtask

   task automatic do_reset(input string req);
      @(posedge clk);
      #1;
      rst_n = 1'b0;
      cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
      @(negedge clk);
      check(state_o == 3'd0, "R13", "reset state_o", int'(state_o), 0);
      check(err_flag == 1'b0, "R13", "reset err_flag", int'(err_flag), 0);
      check(err_code == 7'd0, "R13", "reset err_code", int'(err_code), 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      tag = req;
   endtask

   initial begin
      // R1: every command in a context where it is legal
      do_reset("R1");
      drive(C_ACT, 0, 0); drive(C_NOP, 0, 0); drive(C_ACT, 1, 0);
      drive(C_READ, 0, 0); drive(C_WRITE, 1, 0); drive(C_BST, 0, 0); drive(C_DESL, 0, 0);
      idle_n(2);
      drive(C_PRE, 0, 1);
      settle(0, 0, -1, "R1");
      drive(C_MRS, 0, 0);
      settle(0, 4, -1, "R1");

      // R2: state follows open banks
      do_reset("R2");
      drive(C_ACT, 1, 0);
      settle(0, 1, -1, "R2");
      idle_n(T_RAS - 2);
      drive(C_PRE, 1, 0);
      settle(0, 0, -1, "R2");

      // R3: quiet commands change nothing
      do_reset("R3");
      drive(C_ACT, 0, 0); drive(C_BST, 1, 1); drive(C_DESL, 1, 0); drive(C_NOP, 0, 1);
      settle(0, 1, -1, "R3");

      // R4: refresh then mode load, each exactly at expiry
      do_reset("R4");
      drive(C_REF, 0, 0);
      settle(0, 3, -1, "R4");
      idle_n(T_RP - 2);
      drive(C_MRS, 0, 0);
      settle(0, 4, -1, "R4");
      idle_n(T_MCD - 2);
      drive(C_ACT, 0, 0);
      settle(0, 1, -1, "R4");
      drive(C_REF, 0, 0);
      settle(1, 1, C_REF * 8 + 1, "R4");

      // R5: activate during refresh
      do_reset("R5");
      drive(C_REF, 0, 0); drive(C_ACT, 0, 0);
      settle(1, -1, C_ACT * 8 + 3, "R5");

      // R6: write recovery and bank close at expiry
      do_reset("R6");
      drive(C_ACT, 0, 0); drive(C_WRITE, 0, 1);
      settle(0, 2, -1, "R6");
      idle_n(T_DAL - 2);
      drive(C_ACT, 0, 0);
      settle(0, 1, -1, "R6");

      // R7: other bank usable, recovering bank not
      do_reset("R7");
      drive(C_ACT, 0, 0); drive(C_NOP, 0, 0); drive(C_ACT, 1, 0);
      drive(C_WRITE, 0, 1); drive(C_READ, 1, 0);
      settle(0, 2, -1, "R7");
      drive(C_READ, 0, 0);
      settle(1, -1, C_READ * 8 + 2, "R7");
      do_reset("R7");
      drive(C_ACT, 0, 0); drive(C_WRITE, 0, 1); drive(C_REF, 0, 0);
      settle(1, -1, C_REF * 8 + 2, "R7");

      // R8: activate spacing and double activate
      do_reset("R8");
      drive(C_ACT, 0, 0); drive(C_ACT, 1, 0);
      settle(1, -1, C_ACT * 8 + 1, "R8");
      do_reset("R8");
      drive(C_ACT, 0, 0); drive(C_NOP, 0, 0); drive(C_ACT, 1, 0);
      settle(0, 1, -1, "R8");
      drive(C_ACT, 1, 0);
      settle(1, -1, C_ACT * 8 + 1, "R8");

      // R9: row-active interval on precharge
      do_reset("R9");
      drive(C_ACT, 0, 0); idle_n(T_RAS - 2); drive(C_PRE, 0, 0);
      settle(1, -1, C_PRE * 8 + 1, "R9");
      do_reset("R9");
      drive(C_PRE, 1, 0); drive(C_ACT, 0, 0); idle_n(T_RAS - 1); drive(C_PRE, 0, 0);
      settle(0, 0, -1, "R9");
      drive(C_ACT, 0, 0); idle_n(T_RAS - 1); drive(C_ACT, 1, 0); drive(C_PRE, 0, 1);
      settle(1, -1, C_PRE * 8 + 1, "R9");

      // R10: reads need an open row; read with auto-precharge closes it
      do_reset("R10");
      drive(C_READ, 0, 0);
      settle(1, 0, C_READ * 8 + 0, "R10");
      do_reset("R10");
      drive(C_ACT, 0, 0); drive(C_READ, 0, 1);
      settle(0, 0, -1, "R10");
      drive(C_WRITE, 0, 0);
      settle(1, -1, C_WRITE * 8 + 0, "R10");

      // R11: sleep entry, ignored pins, wake-up
      do_reset("R11");
      for (int i = 0; i < 6; i++) drive(C_PDN, 0, 0);
      @(negedge clk);
      check(state_o == 3'd5, "R11", "sleep state_o", int'(state_o), 5);
      check(err_flag == 1'b0, "R11", "sleep err_flag", int'(err_flag), 0);
      drive(C_ACT, 0, 0);
      settle(0, 1, -1, "R11");
      drive(C_PDN, 0, 0);
      settle(1, -1, C_PDN * 8 + 1, "R11");

      // R12: first error held, tracking continues
      do_reset("R12");
      drive(C_READ, 1, 0); drive(C_MRS, 0, 0); drive(C_ACT, 0, 0); drive(C_ACT, 0, 0);
      settle(1, 1, C_READ * 8 + 0, "R12");

      // mixed random traffic with periodic reset
      for (int k = 0; k < 120; k++) begin
         do_reset("R12");
         for (int j = 0; j < 14; j++)
            drive($urandom_range(0, 9), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      idle_n(2);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL R12 watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule